// File: doc/BRIEF.md
# Integer Multiply-Accumulate and Divide Unit

This block is the integer multiply and divide engine of a processor core. It keeps a 64-bit result held as two 32-bit words, a high word and a low word. It runs signed or unsigned 32x32 multiplication in a single cycle and can add the product onto the current 64-bit high:low value in the same cycle. It also divides two 32-bit operands, signed or unsigned, with a restoring divider that produces one quotient bit per cycle.

The pipeline issues an operation by pulsing `start_i` with an operation code and two operands. While a division is running, `busy_o` is high so that the pipeline can stall. The high and low words are driven on `hi_o` and `lo_o`. Each word can also be loaded directly through a shared write-data port that has its own write enable for each word.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hi_o` and `lo_o` are zero and `busy_o` is low.
- R2: The operation codes are 0 = signed multiply, 1 = unsigned multiply, 2 = signed multiply-add, 3 = unsigned multiply-add, 4 = signed divide and 5 = unsigned divide. A multiply accepted at a clock edge places the 64-bit product on `{hi_o,lo_o}` after that edge, with the upper word in `hi_o`.
- R3: Code 1 treats both operands as unsigned, so an operand with bit 31 set counts as a large positive value.
- R4: Code 2 writes `a*b + {hi,lo}` back to `{hi_o,lo_o}` in one cycle. The product is signed and the sum wraps modulo 2^64.
- R5: Code 3 does the same as code 2 with an unsigned product.
- R6: A divide raises `busy_o` from the edge that accepts it, for exactly 32 cycles. The quotient appears on `lo_o` and the remainder on `hi_o` at the same edge where `busy_o` falls.
- R7: A signed quotient is rounded toward zero, and a signed remainder has the sign of the dividend. Dividing the most negative value by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R8: Code 5 divides the operands as unsigned values.
- R9: Division by zero raises no trap and completes in the same 32 cycles. The same operands always leave the same values.
- R10: When the unit is idle and no start is presented, `hi_we_i` or `lo_we_i` loads `wdata_i` into that word at the next edge. Each word is written independently of the other.
- R11: A start presented in the same cycle as a direct write wins, and the direct write is dropped.
- R12: While `busy_o` is high, `start_i`, `hi_we_i` and `lo_we_i` are ignored. The running divide finishes with its own result and its own timing.
- R13: Codes 6 and 7 change nothing, do not raise `busy_o`, and still suppress a direct write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for the operation on `op_i` |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand (multiplicand or dividend) |
| b_i | input | 32 | Second operand (multiplier or divisor) |
| hi_we_i | input | 1 | Direct write enable for the high word |
| lo_we_i | input | 1 | Direct write enable for the low word |
| wdata_i | input | 32 | Data for direct writes |
| hi_o | output | 32 | High word: upper product half or remainder |
| lo_o | output | 32 | Low word: lower product half or quotient |
| busy_o | output | 1 | High while a division is in progress |

## Verification
Multiplies and divides are applied to every pairing of the corner values 0, 1, -1, 0x7fffffff and 0x80000000, and then to random operands. Both the signed and the unsigned code are used for each operation, so a signedness decode error shows up whenever an operand has bit 31 set. Multiply-adds are chained on top of one another so that the accumulated value reaches the carry out of the low word and wraps at 64 bits. The divide tests cover negative dividends and negative divisors separately, the most-negative/-1 case and a zero divisor. Further cases present a start together with a direct write, and a start or a write while a divide is busy, and each of these checks that the division runs for exactly 32 cycles.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_MAC_S = 3'd2,
    OP_MAC_U = 3'd3,
    OP_DIV_S = 3'd4,
    OP_DIV_U = 3'd5
  } md_op_e;

  function automatic logic op_is_mul(input logic [2:0] op);
    return op[2] == 1'b0;
  endfunction

  function automatic logic op_is_div(input logic [2:0] op);
    return op[2:1] == 2'b10;
  endfunction

  function automatic logic op_signed(input logic [2:0] op);
    return op[0] == 1'b0;
  endfunction
endpackage

// File: rtl/muldiv_mac.sv
module muldiv_mac #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2*W-1:0] acc_i,
  input  logic           signed_i,
  input  logic           accum_i,
  output logic [2*W-1:0] res_o
);
  logic [2*W-1:0] xa, xb, prod;

  // extend to 2W; the product modulo 2^2W is exact for both signednesses
  always_comb begin
    xa    = {{W{signed_i & a_i[W-1]}}, a_i};
    xb    = {{W{signed_i & b_i[W-1]}}, b_i};
    prod  = xa * xb;
    res_o = prod + (accum_i ? acc_i : '0);
  end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          negq_q, negr_q;

  logic [W:0]    shifted;
  logic [W-1:0]  sub, rem_n, quo_n;
  logic          ge;
  logic [W-1:0]  a_mag, b_mag;

  always_comb begin
    a_mag   = (signed_i && a_i[W-1]) ? -a_i : a_i;
    b_mag   = (signed_i && b_i[W-1]) ? -b_i : b_i;
    shifted = {rem_q, quo_q[W-1]};
    ge      = shifted >= {1'b0, dvs_q};
    sub     = shifted[W-1:0] - dvs_q;
    rem_n   = ge ? sub : shifted[W-1:0];
    quo_n   = {quo_q[W-2:0], ge};
    quo_o   = negq_q ? -quo_n : quo_n;
    rem_o   = negr_q ? -rem_n : rem_n;
    busy_o  = cnt_q != '0;
    done_o  = cnt_q == CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CW'(W);
      rem_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      negq_q <= signed_i && (a_i[W-1] ^ b_i[W-1]);
      negr_q <= signed_i && a_i[W-1];
    end else if (busy_o) begin
      cnt_q  <= cnt_q - CW'(1);
      rem_q  <= rem_n;
      quo_q  <= quo_n;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         hi_we_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         busy_o
);
  logic [W-1:0]   hi_q, lo_q;
  logic           accept, mul_go, div_go;
  logic           div_busy, div_done;
  logic [W-1:0]   div_quo, div_rem;
  logic [2*W-1:0] mac_res;

  assign accept = start_i && !div_busy;
  assign mul_go = accept && op_is_mul(op_i);
  assign div_go = accept && op_is_div(op_i);

  muldiv_mac #(.W(W)) u_mac (
    .a_i      (a_i),
    .b_i      (b_i),
    .acc_i    ({hi_q, lo_q}),
    .signed_i (op_signed(op_i)),
    .accum_i  (op_i[1]),
    .res_o    (mac_res)
  );

  muldiv_div #(.W(W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (div_go),
    .signed_i (op_signed(op_i)),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quo_o    (div_quo),
    .rem_o    (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (mul_go) begin
      {hi_q, lo_q} <= mac_res;
    end else if (div_done) begin
      hi_q <= div_rem;
      lo_q <= div_quo;
    end else if (!div_busy && !start_i) begin
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i) lo_q <= wdata_i;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign busy_o = div_busy;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         hi_we_i,
  input logic         lo_we_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         busy_o
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + CW'(1);
    else             bcnt <= '0;
  end

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i) && ($past(op_i) == 3'd4 || $past(op_i) == 3'd5));

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bcnt) == CW'(W - 1));

  // R6
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt < CW'(W));

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && bcnt != CW'(W - 1) |=> $stable(hi_o) && $stable(lo_o));

  // R3
  mulu_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_i == 3'd1 |=>
      {hi_o, lo_o} == {{W{1'b0}}, $past(a_i)} * {{W{1'b0}}, $past(b_i)});

  // R10
  hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i && hi_we_i |=> hi_o == $past(wdata_i));

  // R10
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i && lo_we_i |=> lo_o == $past(wdata_i));

  // R13
  reserved_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_i[2:1] == 2'b11 |=> $stable(hi_o) && $stable(lo_o) && !busy_o);
endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .hi_we_i (hi_we_i),
  .lo_we_i (lo_we_i),
  .wdata_i (wdata_i),
  .hi_o    (hi_o),
  .lo_o    (lo_o),
  .busy_o  (busy_o)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0, wdata = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] hi, lo;
  logic        busy;
  int          checks = 0, errors = 0;

  localparam logic [31:0] CORNER [5] = '{32'h0, 32'h1, 32'hffff_ffff, 32'h7fff_ffff, 32'h8000_0000};

  always #5 clk = ~clk;

  muldiv_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .hi_we_i(hi_we), .lo_we_i(lo_we), .wdata_i(wdata),
    .hi_o(hi), .lo_o(lo), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic sgn, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy;
    if (sgn) begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      return 64'(sx * sy);
    end
    return {32'h0, x} * {32'h0, y};
  endfunction

  function automatic logic [63:0] ref_div(input logic sgn, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, q, r;
    if (sgn) begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      q = sx / sy;
      r = sx % sy;
      return {r[31:0], q[31:0]};
    end
    return {x % y, x / y};
  endfunction

  task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_div(output int cyc);
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 hi/lo", {hi, lo}, 64'h0);
    chk("R1 busy", {63'h0, busy}, 64'h0);
  endtask

  task automatic t_mul;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int s = 0; s < 2; s++) begin
          issue(3'(s), CORNER[i], CORNER[j]);
          chk(s == 0 ? "R2 signed mul corner" : "R3 unsigned mul corner",
              {hi, lo}, ref_mul(s == 0, CORNER[i], CORNER[j]));
        end
    for (int k = 0; k < 40; k++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      issue(3'(k % 2), x, y);
      chk((k % 2) == 0 ? "R2 signed mul rand" : "R3 unsigned mul rand",
          {hi, lo}, ref_mul((k % 2) == 0, x, y));
    end
  endtask

  task automatic t_madd;
    logic [63:0] acc;
    for (int k = 0; k < 30; k++) begin
      logic [31:0] x, y;
      logic        sgn;
      x = (k < 5) ? CORNER[k] : $urandom;
      y = (k < 5) ? 32'hffff_ffff : $urandom;
      sgn = (k % 2) == 0;
      acc = {hi, lo};
      issue(sgn ? 3'd2 : 3'd3, x, y);
      chk(sgn ? "R4 signed madd" : "R5 unsigned madd", {hi, lo}, ref_mul(sgn, x, y) + acc);
    end
    // carry from low into high word and 64-bit wrap
    @(negedge clk); hi_we = 1'b1; lo_we = 1'b1; wdata = 32'hffff_ffff;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0;
    issue(3'd3, 32'h2, 32'h1);
    chk("R5 madd wrap", {hi, lo}, 64'h1);
    issue(3'd2, 32'hffff_ffff, 32'h1);
    chk("R4 madd negative product", {hi, lo}, 64'h0);
  endtask

  task automatic div_one(input logic sgn, input logic [31:0] x, input logic [31:0] y, input string req);
    int cyc;
    issue(sgn ? 3'd4 : 3'd5, x, y);
    wait_div(cyc);
    chk("R6 busy cycles", 64'(cyc), 64'd32);
    chk(req, {hi, lo}, ref_div(sgn, x, y));
  endtask

  task automatic t_div;
    for (int i = 0; i < 5; i++)
      for (int j = 1; j < 5; j++) begin
        div_one(1'b1, CORNER[i], CORNER[j], "R7 signed div corner");
        div_one(1'b0, CORNER[i], CORNER[j], "R8 unsigned div corner");
      end
    div_one(1'b1, 32'hffff_fff9, 32'h2, "R7 neg dividend");
    div_one(1'b1, 32'h7, 32'hffff_fffe, "R7 neg divisor");
    div_one(1'b1, 32'h8000_0000, 32'hffff_ffff, "R7 most negative by -1");
    for (int k = 0; k < 20; k++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom >> (k % 24);
      if (y == 0) y = 32'h3;
      div_one((k % 2) == 0, x, y, (k % 2) == 0 ? "R7 signed div rand" : "R8 unsigned div rand");
    end
  endtask

  task automatic t_div0;
    int cyc;
    logic [63:0] r1;
    issue(3'd4, 32'h1234_5678, 32'h0);
    wait_div(cyc);
    chk("R9 div by zero cycles", 64'(cyc), 64'd32);
    r1 = {hi, lo};
    @(negedge clk); hi_we = 1'b1; lo_we = 1'b1; wdata = 32'h5a5a_5a5a;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0;
    issue(3'd4, 32'h1234_5678, 32'h0);
    wait_div(cyc);
    chk("R9 div by zero repeatable", {hi, lo}, r1);
  endtask

  task automatic t_move;
    @(negedge clk); hi_we = 1'b1; wdata = 32'hdead_beef;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wdata = 32'h0bad_f00d;
    chk("R10 hi write", {32'h0, hi}, {32'h0, 32'hdead_beef});
    @(negedge clk); lo_we = 1'b0;
    chk("R10 lo write keeps hi", {hi, lo}, {32'hdead_beef, 32'h0bad_f00d});
  endtask

  task automatic t_override;
    @(negedge clk);
    start = 1'b1; op = 3'd1; a = 32'h10; b = 32'h20;
    hi_we = 1'b1; lo_we = 1'b1; wdata = 32'h1111_1111;
    @(negedge clk);
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    chk("R11 start beats write", {hi, lo}, 64'h200);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    issue(3'd5, 32'd1000, 32'd7);
    start = 1'b1; op = 3'd1; a = 32'h3; b = 32'h3;
    hi_we = 1'b1; lo_we = 1'b1; wdata = 32'h7777_7777;
    repeat (5) @(negedge clk);
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    chk("R12 hold during busy", {hi, lo}, 64'h200);
    wait_div(cyc);
    chk("R12 busy length", 64'(cyc + 5), 64'd32);
    chk("R12 divide result", {hi, lo}, {32'd6, 32'd142});
  endtask

  task automatic t_reserved;
    for (int c = 6; c < 8; c++) begin
      @(negedge clk);
      start = 1'b1; op = 3'(c); a = 32'h5; b = 32'h6;
      hi_we = 1'b1; lo_we = 1'b1; wdata = 32'hcccc_cccc;
      @(negedge clk);
      start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
      chk("R13 reserved no change", {hi, lo}, {32'd6, 32'd142});
      chk("R13 reserved not busy", {63'h0, busy}, 64'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_madd();
    t_div();
    t_div0();
    t_move();
    t_override();
    t_busy_ignore();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule